// File: doc/BRIEF.md
# Serial Card Board-Select and Bus-Steering Decoder

This block decides when a serial I/O card on an 8-bit processor backplane owns the current bus cycle. It then steers the card's on-board data buffers and read paths. Two selection schemes are supported, chosen by a static mode input that stands in for a jumper.

In port mode, the card answers an I/O cycle: one of the processor's input or output status strobes must be active, and address bits 7..4 must equal a configured 4-bit board number. In memory mode, the card answers a memory cycle instead. Both status strobes must be idle, the upper address byte must equal 0xFE, and bits 7..4 must still match the board number.

Once the card is enabled, the data-bus-in strobe sets the buffer direction. Address bit 3 splits accesses between the on-board control port and the serial controller. All outputs are combinational functions of the present inputs. The clock and reset inputs serve only the embedded property checks.

Top module: `sio_board_decode`

## Requirements
- R1: With mode_i=0 (port mode), board_en_o is 1 exactly when addr_i[7:4]==base_i and at least one of sinp_i, sout_i is 1; addr_i[15:8] has no effect.
- R2: With mode_i=1 (memory mode), board_en_o is 1 exactly when addr_i[7:4]==base_i, addr_i[15:8]==8'hFE and both sinp_i and sout_i are 0.
- R3: When addr_i[7:4] differs from base_i, board_en_o is 0 in either mode, whatever the strobes and upper byte.
- R4: buf_en_o follows board_en_o; when the board is not enabled, buf_en_o and buf_to_cpu_o are 0 whatever dbin_i is.
- R5: buf_to_cpu_o is 1 (buffers drive toward the processor) exactly when the board is enabled and dbin_i is 1; otherwise an enabled buffer drives toward the board.
- R6: ctrl_rd_o is 1 exactly when the board is enabled, dbin_i is 1 and addr_i[3] is 1.
- R7: dev_sel_o (serial controller select) is 1 exactly when the board is enabled and addr_i[3] is 0; ctrl_rd_o and dev_sel_o are never both 1.
- R8: The block holds no state: outputs reflect the present inputs in the same cycle, and rst_ni has no effect on them (all inputs 0 gives all outputs 0, in reset or not).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock used only by property checks |
| rst_ni | input | 1 | Active-low asynchronous reset, gates property checks |
| addr_i | input | 16 | Processor address bus |
| mode_i | input | 1 | 0 = port mode, 1 = memory mode (static) |
| base_i | input | 4 | Configured board number compared with addr_i[7:4] |
| sinp_i | input | 1 | Input-cycle status strobe |
| sout_i | input | 1 | Output-cycle status strobe |
| dbin_i | input | 1 | Data-bus-in strobe from the processor |
| board_en_o | output | 1 | Card selected for this cycle |
| buf_en_o | output | 1 | On-board data buffer enable |
| buf_to_cpu_o | output | 1 | Buffer direction, 1 = toward processor |
| ctrl_rd_o | output | 1 | Control-port read gate onto on-board bus |
| dev_sel_o | output | 1 | Serial controller access select |

## Verification
The properties sample the combinational outputs at the clock edge. They therefore assume that every input has settled well before that edge and that mode_i is changed only while both status strobes are idle. The stimulus meets both conditions. Each vector is applied shortly after a rising edge and held for a full cycle. Before a mode change, a vector with both strobes low is applied, and the new mode is set while the strobes are still idle. Random vectors are mixed with addresses forced onto the board number and the 0xFE page, so that every enable path is reached in both modes.

// File: rtl/sio_dec_pkg.sv
package sio_dec_pkg;
  typedef enum logic {
    MODE_PORT = 1'b0,
    MODE_MEM  = 1'b1
  } sel_mode_e;

  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned NIB_W    = 4;
  localparam int unsigned NIB_LSB  = 4;
  localparam int unsigned HI_W     = 8;
  localparam int unsigned CTRL_BIT = 3;
  localparam logic [HI_W-1:0] MEM_PAGE = 8'hFE;
endpackage

// File: rtl/sio_dec_match.sv
module sio_dec_match
  import sio_dec_pkg::*;
#(
  parameter int unsigned NW = NIB_W,
  parameter int unsigned HW = HI_W,
  parameter logic [HW-1:0] PAGE = MEM_PAGE
) (
  input  sel_mode_e     mode_i,
  input  logic [NW-1:0] nib_i,
  input  logic [NW-1:0] base_i,
  input  logic [HW-1:0] hi_i,
  output logic          hit_o
);
  logic nib_hit, page_hit;

  assign nib_hit  = (nib_i == base_i);
  // port mode bypasses the page compare
  assign page_hit = (mode_i == MODE_PORT) || (hi_i == PAGE);
  assign hit_o    = nib_hit && page_hit;
endmodule

// File: rtl/sio_dec_qual.sv
module sio_dec_qual
  import sio_dec_pkg::*;
(
  input  sel_mode_e mode_i,
  input  logic      sinp_i,
  input  logic      sout_i,
  output logic      ok_o
);
  logic io_cycle;

  assign io_cycle = sinp_i | sout_i;
  always_comb begin
    unique case (mode_i)
      MODE_PORT: ok_o = io_cycle;
      MODE_MEM:  ok_o = !io_cycle;
      default:   ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sio_dec_steer.sv
module sio_dec_steer (
  input  logic en_i,
  input  logic dbin_i,
  input  logic sel_bit_i,
  output logic buf_en_o,
  output logic buf_to_cpu_o,
  output logic ctrl_rd_o,
  output logic dev_sel_o
);
  assign buf_en_o     = en_i;
  assign buf_to_cpu_o = en_i && dbin_i;
  assign ctrl_rd_o    = en_i && dbin_i && sel_bit_i;
  assign dev_sel_o    = en_i && !sel_bit_i;
endmodule

// File: rtl/sio_board_decode.sv
module sio_board_decode
  import sio_dec_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned NW  = NIB_W,
  parameter int unsigned NL  = NIB_LSB,
  parameter int unsigned HW  = HI_W,
  parameter int unsigned CB  = CTRL_BIT,
  parameter logic [HW-1:0] PAGE = MEM_PAGE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          mode_i,
  input  logic [NW-1:0] base_i,
  input  logic          sinp_i,
  input  logic          sout_i,
  input  logic          dbin_i,
  output logic          board_en_o,
  output logic          buf_en_o,
  output logic          buf_to_cpu_o,
  output logic          ctrl_rd_o,
  output logic          dev_sel_o
);
  localparam int unsigned NH = NL + NW - 1;
  localparam int unsigned HL = AW - HW;

  sel_mode_e mode;
  logic      addr_hit, strobe_ok;
  logic      unused_low;

  assign mode       = sel_mode_e'(mode_i);
  assign unused_low = ^addr_i[CB-1:0];

  sio_dec_match #(.NW(NW), .HW(HW), .PAGE(PAGE)) u_match (
    .mode_i (mode),
    .nib_i  (addr_i[NH:NL]),
    .base_i (base_i),
    .hi_i   (addr_i[AW-1:HL]),
    .hit_o  (addr_hit)
  );

  sio_dec_qual u_qual (
    .mode_i (mode),
    .sinp_i (sinp_i),
    .sout_i (sout_i),
    .ok_o   (strobe_ok)
  );

  assign board_en_o = addr_hit && strobe_ok;

  sio_dec_steer u_steer (
    .en_i         (board_en_o),
    .dbin_i       (dbin_i),
    .sel_bit_i    (addr_i[CB]),
    .buf_en_o     (buf_en_o),
    .buf_to_cpu_o (buf_to_cpu_o),
    .ctrl_rd_o    (ctrl_rd_o),
    .dev_sel_o    (dev_sel_o)
  );

  assert_port_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && board_en_o) |-> (sinp_i || sout_i));
  assert_mem_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && board_en_o) |-> (!sinp_i && !sout_i && addr_i[AW-1:HL] == PAGE));
  assert_nib_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    board_en_o |-> (addr_i[NH:NL] == base_i));
  assert_buf_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !board_en_o |-> (!buf_en_o && !buf_to_cpu_o));
  assert_dir_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_to_cpu_o |-> (buf_en_o && dbin_i));
  assert_ctrl_rd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rd_o |-> (board_en_o && dbin_i && addr_i[CB]));
  assert_split_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_rd_o, dev_sel_o}));
endmodule

// File: tb/sio_board_decode_bench.sv
module sio_board_decode_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        mode = 1'b0;
  logic [3:0]  base = '0;
  logic        sinp = 1'b0, sout = 1'b0, dbin = 1'b0;
  logic        en, ben, tocpu, crd, dsel;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [4:0] exp;
    string      req;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  sio_board_decode u_sio_board_decode (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .mode_i(mode), .base_i(base),
    .sinp_i(sinp), .sout_i(sout), .dbin_i(dbin),
    .board_en_o(en), .buf_en_o(ben), .buf_to_cpu_o(tocpu),
    .ctrl_rd_o(crd), .dev_sel_o(dsel)
  );

  function automatic logic [4:0] model(logic [15:0] a, logic m, logic [3:0] b,
                                       logic si, logic so, logic di);
    logic e;
    if (a[7:4] != b) e = 1'b0;                              // R3
    else if (!m)     e = si || so;                          // R1
    else             e = (a[15:8] == 8'hFE) && !si && !so;  // R2
    return {e, e, e && di, e && di && a[3], e && !a[3]};    // R4..R7
  endfunction

  task automatic drive(logic [15:0] a, logic m, logic [3:0] b,
                       logic si, logic so, logic di, string req);
    item_t it;
    @(posedge clk);
    #1;
    addr = a; mode = m; base = b; sinp = si; sout = so; dbin = di;
    it.exp = model(a, m, b, si, so, di);
    it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [4:0] act;
      it = sb_q.pop_front();
      act = {en, ben, tocpu, crd, dsel};
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: outputs {en,buf,to_cpu,ctrl,dev} act=%b exp=%b addr=%h mode=%b base=%h",
                 it.req, act, it.exp, addr, mode, base);
      end
    end
  end

  initial begin
    repeat (1000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R8: reset state, all inputs idle
    drive(16'h0000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, "R8");
    // R8: outputs respond while still in reset
    drive(16'h0038, 1'b0, 4'h3, 1'b1, 1'b0, 1'b1, "R8");
    @(posedge clk); #2 rst_n = 1'b1;
    drive(16'h0000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, "R8");

    // R1: port mode, upper byte ignored
    drive(16'h1234, 1'b0, 4'h3, 1'b1, 1'b0, 1'b1, "R1");
    drive(16'hFF34, 1'b0, 4'h3, 1'b0, 1'b1, 1'b0, "R1");
    drive(16'h0030, 1'b0, 4'h3, 1'b0, 1'b0, 1'b1, "R1");
    drive(16'h00A8, 1'b0, 4'hA, 1'b1, 1'b1, 1'b1, "R6");
    drive(16'h00A8, 1'b0, 4'hA, 1'b0, 1'b1, 1'b0, "R5");
    drive(16'h00A0, 1'b0, 4'hA, 1'b1, 1'b0, 1'b1, "R7");
    // R3: nibble mismatch
    drive(16'h00B8, 1'b0, 4'hA, 1'b1, 1'b0, 1'b1, "R3");
    // R4: disabled with dbin high
    drive(16'h00B0, 1'b0, 4'hA, 1'b0, 1'b0, 1'b1, "R4");

    // mode change with strobes idle
    drive(16'h0000, 1'b1, 4'h5, 1'b0, 1'b0, 1'b0, "R2");
    drive(16'hFE58, 1'b1, 4'h5, 1'b0, 1'b0, 1'b1, "R2");
    drive(16'hFE50, 1'b1, 4'h5, 1'b0, 1'b0, 1'b0, "R7");
    drive(16'hFD58, 1'b1, 4'h5, 1'b0, 1'b0, 1'b1, "R2");
    drive(16'hFE58, 1'b1, 4'h5, 1'b1, 1'b0, 1'b1, "R2");
    drive(16'hFE68, 1'b1, 4'h5, 1'b0, 1'b0, 1'b1, "R3");
    drive(16'hFE5F, 1'b1, 4'h5, 1'b0, 1'b0, 1'b1, "R6");

    for (int m = 0; m < 2; m++) begin
      drive(16'h0000, m[0], 4'h0, 1'b0, 1'b0, 1'b0, "R8");
      for (int i = 0; i < 150; i++) begin
        logic [15:0] a;
        logic [3:0]  b;
        logic [2:0]  s;
        a = 16'($urandom);
        b = 4'($urandom);
        s = 3'($urandom);
        if (s[0]) a[7:4] = b;
        if (m == 1 && s[1]) a[15:8] = 8'hFE;
        drive(a, m[0], b, (m == 1 && s[2]) ? 1'b0 : 1'($urandom),
              (m == 1 && s[2]) ? 1'b0 : 1'($urandom), 1'($urandom),
              m == 0 ? "R1" : "R2");
      end
      drive(16'h0000, m[0], 4'h0, 1'b0, 1'b0, 1'b0, "R3");
    end

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule